// File: doc/BRIEF.md
# Timing-State Control Sequencer

This block is the control unit of a small accumulator machine. A one-hot ring of six timing states steps through three fetch states and three execute states for every instruction. In each state the block combines the current timing state with the 4-bit operation code held in the machine's instruction register. From these two inputs it drives a 12-line control word. That word tells the program counter, address register, memory, instruction register, accumulator, operand register, adder and output port what to do at the next rising clock edge.

The ring advances on the falling clock edge. The datapath therefore sees a stable control word across each rising edge in the middle of a state. A halt operation freezes the ring and raises a halt flag. Only the clear input brings the sequencer back to the first state. The datapath itself lies outside the block.

Top module: `tseq_top`

## Requirements
- R1: While `rst` is high at a falling edge, the sequencer returns to the first timing state and `halted` goes low. In that state the control word is 0x5E3.
- R2: Each falling clock edge with `rst` low and no halt moves the ring one state forward through six states. After the sixth state it goes back to the first.
- R3: The three fetch states emit 0x5E3, 0xBE3 and 0x263, in that order, whatever opcode is present.
- R4: Opcode 0000 (load accumulator) gives 0x1A3, 0x2C3 and 0x3E3 in the three execute states.
- R5: Opcode 0001 (add) gives 0x1A3, 0x2E1 and 0x3C7 in the three execute states.
- R6: Opcode 0010 (subtract) gives 0x1A3, 0x2E1 and 0x3CF; the subtract line (bit 3) is high only in the last state.
- R7: Opcode 1110 (output) gives 0x3F2, 0x3E3 and 0x3E3 in the three execute states.
- R8: Opcode 1111 (halt) gives 0x3E3 in the fourth state. `halted` rises at the falling edge that ends that state. After that the ring holds and the word stays 0x3E3 until clear, whatever the opcode does.
- R9: Any other opcode is a no-op and gives 0x3E3 in all three execute states.
- R10: When clear and a halt decision meet at the same falling edge, clear wins: the next state is the first one and `halted` stays low.
- R11: Control word bits from 11 down to 0 are: count, PC drive, address load (low), memory drive (low), IR load (low), IR drive (low), accumulator load (low), accumulator drive, subtract, adder drive, operand load (low), output load (low). At most one bus driver is active at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ring and halt flag update on its falling edge |
| rst | input | 1 | Synchronous active-high clear, sampled on the falling edge |
| opcode | input | 4 | Operation code (upper nibble of the instruction register) |
| ctrl_word | output | 12 | Control word for the current timing state |
| halted | output | 1 | High once a halt operation has been executed |

## Verification
Two things can meet at one falling edge: the halt decision at the end of the fourth state and a clear. The bench brings them together by running a halt instruction and raising clear during its fourth state, so both are sampled at the same edge. It judges the result from the next rising edge, which must show the first fetch word with the halt flag low. It then runs a full load instruction to confirm that the ring moves on normally. A separate run lets the halt take effect, then changes the opcode while the ring is frozen, to show that the frozen state cannot decode a new execute word.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

  localparam int NUM_T = 6;
  localparam int OP_W  = 4;
  localparam int CW_W  = 12;

  // timing-state indices in the ring
  localparam int T_ADDR = 0;
  localparam int T_INCR = 1;
  localparam int T_MEM  = 2;
  localparam int T_EX1  = 3;
  localparam int T_EX2  = 4;
  localparam int T_EX3  = 5;

  // control-word bit positions (the datapath decodes these)
  localparam int B_CP  = 11;
  localparam int B_EP  = 10;
  localparam int B_LM  = 9;
  localparam int B_CE  = 8;
  localparam int B_LI  = 7;
  localparam int B_EI  = 6;
  localparam int B_LA  = 5;
  localparam int B_EA  = 4;
  localparam int B_SU  = 3;
  localparam int B_EU  = 2;
  localparam int B_LB  = 1;
  localparam int B_LO  = 0;

  localparam logic [OP_W-1:0] OP_LOAD = 4'b0000;
  localparam logic [OP_W-1:0] OP_ADD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_SUB  = 4'b0010;
  localparam logic [OP_W-1:0] OP_OUT  = 4'b1110;
  localparam logic [OP_W-1:0] OP_HALT = 4'b1111;

  // every control action as active-high intent
  typedef struct packed {
    logic cnt;
    logic pc_drv;
    logic adr_ld;
    logic mem_drv;
    logic ir_ld;
    logic ir_drv;
    logic acc_ld;
    logic acc_drv;
    logic sub;
    logic alu_drv;
    logic opd_ld;
    logic out_ld;
  } ctl_act_t;

  localparam ctl_act_t ACT_IDLE = '0;

  // map intent to wire polarity: loads and memory/IR drive are active low
  function automatic logic [CW_W-1:0] pack_word(input ctl_act_t a);
    logic [CW_W-1:0] w;
    w        = '0;
    w[B_CP]  = a.cnt;
    w[B_EP]  = a.pc_drv;
    w[B_LM]  = ~a.adr_ld;
    w[B_CE]  = ~a.mem_drv;
    w[B_LI]  = ~a.ir_ld;
    w[B_EI]  = ~a.ir_drv;
    w[B_LA]  = ~a.acc_ld;
    w[B_EA]  = a.acc_drv;
    w[B_SU]  = a.sub;
    w[B_EU]  = a.alu_drv;
    w[B_LB]  = ~a.opd_ld;
    w[B_LO]  = ~a.out_ld;
    return w;
  endfunction

endpackage

// File: rtl/tseq_ring.sv
module tseq_ring #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] ring
);
  localparam logic [W-1:0] FIRST = W'(1);

  always_ff @(negedge clk) begin
    if (rst)      ring <= FIRST;
    else if (adv) ring <= {ring[W-2:0], ring[W-1]};
  end
endmodule

// File: rtl/tseq_halt.sv
module tseq_halt #(
  parameter int                OP_W    = 4,
  parameter logic [OP_W-1:0]   HALT_OP = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            at_exec,
  input  logic [OP_W-1:0] opcode,
  output logic            halted,
  output logic            freeze
);
  logic hit;

  assign hit    = at_exec && (opcode == HALT_OP) && !halted;
  assign freeze = halted || hit;

  always_ff @(negedge clk) begin
    if (rst)      halted <= 1'b0;
    else if (hit) halted <= 1'b1;
  end
endmodule

// File: rtl/tseq_decode.sv
module tseq_decode
  import tseq_pkg::*;
(
  input  logic [NUM_T-1:0] ring,
  input  logic [OP_W-1:0]  opcode,
  input  logic             halted,
  output logic [CW_W-1:0]  ctrl_word
);
  ctl_act_t act;

  always_comb begin
    act = ACT_IDLE;
    if (!halted) begin
      if (ring[T_ADDR]) begin
        act.pc_drv = 1'b1;
        act.adr_ld = 1'b1;
      end else if (ring[T_INCR]) begin
        act.cnt = 1'b1;
      end else if (ring[T_MEM]) begin
        act.mem_drv = 1'b1;
        act.ir_ld   = 1'b1;
      end else if (ring[T_EX1]) begin
        case (opcode)
          OP_LOAD, OP_ADD, OP_SUB: begin
            act.ir_drv = 1'b1;
            act.adr_ld = 1'b1;
          end
          OP_OUT: begin
            act.acc_drv = 1'b1;
            act.out_ld  = 1'b1;
          end
          default: act = ACT_IDLE;
        endcase
      end else if (ring[T_EX2]) begin
        case (opcode)
          OP_LOAD: begin
            act.mem_drv = 1'b1;
            act.acc_ld  = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            act.mem_drv = 1'b1;
            act.opd_ld  = 1'b1;
          end
          default: act = ACT_IDLE;
        endcase
      end else if (ring[T_EX3]) begin
        case (opcode)
          OP_ADD: begin
            act.alu_drv = 1'b1;
            act.acc_ld  = 1'b1;
          end
          OP_SUB: begin
            act.alu_drv = 1'b1;
            act.acc_ld  = 1'b1;
            act.sub     = 1'b1;
          end
          default: act = ACT_IDLE;
        endcase
      end
    end
  end

  assign ctrl_word = pack_word(act);
endmodule

// File: rtl/tseq_top.sv
module tseq_top
  import tseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      opcode,
  output logic [11:0]     ctrl_word,
  output logic            halted
);
  logic [NUM_T-1:0] ring_q;
  logic             freeze;

  tseq_ring #(.W(NUM_T)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .adv  (!freeze),
    .ring (ring_q)
  );

  tseq_halt #(.OP_W(OP_W), .HALT_OP(OP_HALT)) u_halt (
    .clk     (clk),
    .rst     (rst),
    .at_exec (ring_q[T_EX1]),
    .opcode  (opcode),
    .halted  (halted),
    .freeze  (freeze)
  );

  tseq_decode u_dec (
    .ring      (ring_q),
    .opcode    (opcode),
    .halted    (halted),
    .ctrl_word (ctrl_word)
  );
endmodule

// File: rtl/tseq_chk.sv
module tseq_chk (
  input logic        clk,
  input logic        rst,
  input logic [5:0]  ring,
  input logic        halted,
  input logic [11:0] ctrl_word
);
  logic armed = 1'b0;

  always_ff @(negedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1: clear puts the ring at the first state with the halt flag low
  p_clear_state_r1: assert property (@(negedge clk)
    rst |=> (ring == 6'b000001 && !halted));

  // R2: exactly one timing state is active
  p_ring_onehot_r2: assert property (@(negedge clk) disable iff (rst)
    armed |-> $countones(ring) == 1);

  // R2: without a halt, each falling edge rotates the ring by one
  p_ring_step_r2: assert property (@(negedge clk) disable iff (rst)
    (armed && !$past(rst) && !halted) |-> ring == {$past(ring[4:0]), $past(ring[5])});

  // R8: halt is sticky and freezes the ring
  p_halt_hold_r8: assert property (@(negedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(halted)) |-> (halted && $stable(ring)));

  // R8: a halted sequencer issues only the idle word
  p_halt_idle_r8: assert property (@(posedge clk) disable iff (rst)
    halted |-> ctrl_word == 12'h3E3);

  // R3: first fetch state always routes the PC to the address register
  p_fetch_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (ring[0] && !halted) |-> ctrl_word == 12'h5E3);

  // R11: at most one source drives the shared bus
  p_one_driver_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl_word[10], !ctrl_word[8], !ctrl_word[6], ctrl_word[4], ctrl_word[2]}));
endmodule

bind tseq_top tseq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ring      (ring_q),
  .halted    (halted),
  .ctrl_word (ctrl_word)
);

// File: tb/tseq_top_tb.sv
module tseq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic [11:0] ctrl_word;
  logic        halted;

  typedef struct {
    logic [11:0] w;
    logic        h;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  bit   fresh = 1'b0;

  tseq_top u_dut (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .ctrl_word (ctrl_word),
    .halted    (halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: mid-state rising edge, control word is stable here
  always @(posedge clk) begin
    exp_t e;
    int   drv;
    if (q.size() > 0) begin
      e = q.pop_front();
      total++;
      if (ctrl_word !== e.w || halted !== e.h) begin
        bad++;
        $display("FAIL %s: ctrl=%h halted=%b expected ctrl=%h halted=%b",
                 e.tag, ctrl_word, halted, e.w, e.h);
      end
      // R11: bus driver exclusivity
      drv = int'(ctrl_word[10]) + int'(!ctrl_word[8]) + int'(!ctrl_word[6])
          + int'(ctrl_word[4]) + int'(ctrl_word[2]);
      total++;
      if (drv > 1) begin
        bad++;
        $display("FAIL R11: drivers=%0d expected <=1 (ctrl=%h)", drv, ctrl_word);
      end
    end
  end

  function automatic logic [11:0] exp_exec(input logic [3:0] op, input int i);
    case (op)
      4'b0000: return (i == 0) ? 12'h1A3 : (i == 1) ? 12'h2C3 : 12'h3E3;
      4'b0001: return (i == 0) ? 12'h1A3 : (i == 1) ? 12'h2E1 : 12'h3C7;
      4'b0010: return (i == 0) ? 12'h1A3 : (i == 1) ? 12'h2E1 : 12'h3CF;
      4'b1110: return (i == 0) ? 12'h3F2 : 12'h3E3;
      default: return 12'h3E3;
    endcase
  endfunction

  function automatic logic [11:0] exp_fetch(input int i);
    return (i == 0) ? 12'h5E3 : (i == 1) ? 12'hBE3 : 12'h263;
  endfunction

  task automatic push(input logic [11:0] w, input logic h, input string t);
    exp_t e;
    e.w = w; e.h = h; e.tag = t;
    q.push_back(e);
  endtask

  // step to the next timing state (just after the falling edge)
  task automatic next_state();
    if (fresh) fresh = 1'b0;
    else begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    push(12'h5E3, 1'b0, "R1");
    @(negedge clk);
    #1;
    rst   = 1'b0;
    fresh = 1'b1;
  endtask

  // one full instruction; junk opcode during T1/T2 proves fetch ignores it (R3)
  task automatic run_instr(input logic [3:0] op, input string tag, input string ftag);
    for (int s = 0; s < 6; s++) begin
      next_state();
      opcode = (s < 2) ? ~op : op;
      if (s < 3) push(exp_fetch(s), 1'b0, (s == 0) ? ftag : "R2/R3");
      else       push(exp_exec(op, s - 3), 1'b0, tag);
    end
  endtask

  // R8: halt, then wiggle the opcode while frozen
  task automatic run_halt();
    for (int s = 0; s < 3; s++) begin
      next_state();
      opcode = 4'h0;
      push(exp_fetch(s), 1'b0, "R3");
    end
    next_state();
    opcode = 4'hF;
    push(12'h3E3, 1'b0, "R8");
    for (int k = 0; k < 4; k++) begin
      next_state();
      opcode = (k[0]) ? 4'h1 : 4'hE;
      push(12'h3E3, 1'b1, "R8");
    end
  endtask

  // R10: clear sampled on the same falling edge as the halt decision
  task automatic run_halt_clear();
    for (int s = 0; s < 3; s++) begin
      next_state();
      opcode = 4'h2;
      push(exp_fetch(s), 1'b0, "R3");
    end
    next_state();
    opcode = 4'hF;
    push(12'h3E3, 1'b0, "R8");
    rst = 1'b1;
    @(negedge clk);
    #1;
    rst   = 1'b0;
    fresh = 1'b1;
    run_instr(4'b0000, "R4", "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    total++;
    bad++;
    $display("FAIL R2: watchdog expired, actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // two back-to-back cycles per opcode
    run_instr(4'b0000, "R4", "R2/R3");
    run_instr(4'b0000, "R4", "R2/R3");
    run_instr(4'b0001, "R5", "R2/R3");
    run_instr(4'b0001, "R5", "R2/R3");
    run_instr(4'b0010, "R6", "R2/R3");
    run_instr(4'b0010, "R6", "R2/R3");
    run_instr(4'b1110, "R7", "R2/R3");
    run_instr(4'b1110, "R7", "R2/R3");
    run_instr(4'b0011, "R9", "R2/R3");
    run_instr(4'b0111, "R9", "R2/R3");
    run_instr(4'b1101, "R9", "R2/R3");
    run_halt();
    do_reset();
    run_instr(4'b0001, "R5", "R2/R3");
    run_halt_clear();
    run_instr(4'b0010, "R6", "R2/R3");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule